// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog

This block drives the reset and watchdog outputs of a processor supervisor. It gets two digital flags from comparators outside the block. One flag says the main supply is below its trip level. The other says a second supply is below its own trip level. From these flags it builds a system reset in both polarities. The reset is held from power-up, and it is held again whenever the main supply sags. After the main flag clears, the reset stays on for a programmable hold time. The second-supply flag is passed straight to an active-low fail output, with no delay.

The watchdog listens to the raw two-wire bus lines. A start condition that is later closed by a stop condition counts as proof that the processor is alive, and it restarts the watchdog count. If no such restart arrives within the selected period, the watchdog output goes low for a fixed low time. A one-cycle fail pulse marks the moment it fires. The count then starts again. All times are counted in pulses of a millisecond tick input, and parameters set the tick counts for each code.

Top module: `sup_reset_wdog`

## Requirements
- R1: While `rst_n` is low, `rst_hi` is 1, `rst_lo_n` is 0, `wd_out_n` is 1 and `wd_fail_pulse` is 0. `rst_lo_n` is always the inverse of `rst_hi`.
- R2: With the main-supply flag clear, reset releases on exactly the Nth tick after power-up. N is set by `hold_sel`: 2'b00 = 50, 2'b01 = 200, 2'b10 = 400, 2'b11 = 800 ticks.
- R3: When `vmain_low` is 1, reset is asserted by the next clock. When the flag clears, the full hold time of R2 is counted again from zero.
- R4: `aux_fail_n` equals the inverse of `vaux_low` in the same cycle. It does not depend on reset.
- R5: A `wd_sel` of 2'b11 disables the watchdog, so `wd_out_n` stays 1.
- R6: With no restart, the watchdog fires on the Pth counted tick. P is set by `wd_sel`: 2'b00 = 1400, 2'b01 = 200, 2'b10 = 25 ticks. On firing, `wd_out_n` goes to 0 and `wd_fail_pulse` is 1 for exactly one cycle.
- R7: `wd_out_n` stays 0 for 200 ticks for codes 2'b00 and 2'b01, and for 25 ticks for code 2'b10. Counting for the next period then begins afresh.
- R8: A start condition (SDA falls while SCL is high) that is followed, possibly after data bits, by a stop condition (SDA rises while SCL is high) clears the watchdog count.
- R9: A stop that has no start before it does not restart the watchdog. SDA changes made while SCL is low do not restart it either.
- R10: While reset is asserted, the watchdog is held in its running state with a cleared count, and `wd_out_n` stays 1. Counting starts with the first tick after release.
- R11: A change of `wd_sel` clears the watchdog count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| tick_ms | input | 1 | One-cycle timebase pulse, nominally every millisecond |
| vmain_low | input | 1 | Main supply below its trip level |
| vaux_low | input | 1 | Second supply below its trip level |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| hold_sel | input | 2 | Reset hold time code |
| wd_sel | input | 2 | Watchdog period code |
| rst_hi | output | 1 | System reset, active high |
| rst_lo_n | output | 1 | System reset, active low |
| wd_out_n | output | 1 | Watchdog output, active low |
| aux_fail_n | output | 1 | Second-supply fail, active low |
| wd_fail_pulse | output | 1 | One-cycle pulse when the watchdog fires |

## Verification
The assertions assume three things about the inputs. First, `tick_ms` is a single-cycle pulse. Second, the bus lines stay at each level for several clocks, so the synchronizers never see SCL and SDA move in the same cycle. Third, the code inputs change only at deliberate points. The stimulus follows these rules. Every bus phase is held for three cycles, SCL is lowered before SDA moves off an idle bus, and no ticks are issued while a bus sequence is in flight. That way the expected expiry tick can be counted exactly from the last restart.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic {
        WD_RUN  = 1'b0,
        WD_BARK = 1'b1
    } wd_state_e;

    localparam logic [1:0] WD_SEL_OFF   = 2'b11;
    localparam logic [1:0] WD_SEL_SHORT = 2'b10;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
    parameter int unsigned HOLD_T0 = 50,
    parameter int unsigned HOLD_T1 = 200,
    parameter int unsigned HOLD_T2 = 400,
    parameter int unsigned HOLD_T3 = 800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       low_flag,
    input  logic [1:0] sel,
    output logic       active
);
    import sup_pkg::*;

    localparam int unsigned MAX_T = max2(max2(HOLD_T0, HOLD_T1), max2(HOLD_T2, HOLD_T3));
    localparam int unsigned CW    = $clog2(MAX_T + 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } hold_st_t;

    hold_st_t      st_d, st_q;
    logic [CW-1:0] limit;

    always_comb begin
        case (sel)
            2'b00:   limit = CW'(HOLD_T0);
            2'b01:   limit = CW'(HOLD_T1);
            2'b10:   limit = CW'(HOLD_T2);
            default: limit = CW'(HOLD_T3);
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (low_flag) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active && tick) begin
            if (st_q.cnt >= limit - 1'b1) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= 1'b1;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;

    AST_LOW_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        low_flag |=> active); // R3

    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(tick) && !$past(low_flag))); // R2

endmodule

// File: rtl/sup_bus_kick.sv
module sup_bus_kick #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic kick
);
    localparam int unsigned NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    typedef struct packed {
        logic [NS-1:0][1:0] sync;
        logic [1:0]         prev;
        logic               armed;
        logic               kick;
    } bus_st_t;

    bus_st_t    st_d, st_q;
    logic [1:0] cur;
    logic       scl_hi, start_c, stop_c;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = {scl_raw, sda_raw};
        for (int i = 1; i < NS; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        cur       = st_q.sync[NS-1];
        st_d.prev = cur;
        scl_hi    = cur[1] & st_q.prev[1];
        start_c   = scl_hi &  st_q.prev[0] & ~cur[0];
        stop_c    = scl_hi & ~st_q.prev[0] &  cur[0];
        st_d.kick = stop_c & st_q.armed;
        if (start_c) begin
            st_d.armed = 1'b1;
        end else if (stop_c) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync  <= '1;
            st_q.prev  <= 2'b11;
            st_q.armed <= 1'b0;
            st_q.kick  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kick = st_q.kick;

    AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !kick); // R8

    AST_KICK_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> $past(st_q.armed)); // R9

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int unsigned WDP_T0   = 1400,
    parameter int unsigned WDP_T1   = 200,
    parameter int unsigned WDP_T2   = 25,
    parameter int unsigned WDL_LONG  = 200,
    parameter int unsigned WDL_SHORT = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold_rst,
    input  logic       kick,
    input  logic [1:0] sel,
    output logic       bark,
    output logic       fail_pulse
);
    import sup_pkg::*;

    localparam int unsigned MAX_T = max2(max2(WDP_T0, WDP_T1), max2(WDP_T2, max2(WDL_LONG, WDL_SHORT)));
    localparam int unsigned CW    = $clog2(MAX_T + 1);

    typedef struct packed {
        wd_state_e     st;
        logic [CW-1:0] cnt;
        logic [1:0]    sel_seen;
        logic          pulse;
    } wd_st_t;

    wd_st_t        st_d, st_q;
    logic [CW-1:0] period;
    logic [CW-1:0] lowlen;

    always_comb begin
        case (sel)
            2'b00:   period = CW'(WDP_T0);
            2'b01:   period = CW'(WDP_T1);
            default: period = CW'(WDP_T2);
        endcase
        lowlen = (sel == WD_SEL_SHORT) ? CW'(WDL_SHORT) : CW'(WDL_LONG);
    end

    always_comb begin
        st_d          = st_q;
        st_d.pulse    = 1'b0;
        st_d.sel_seen = sel;
        if (hold_rst || sel == WD_SEL_OFF) begin
            st_d.st  = WD_RUN;
            st_d.cnt = '0;
        end else if (sel != st_q.sel_seen) begin
            st_d.cnt = '0;
        end else begin
            case (st_q.st)
                WD_RUN: begin
                    if (kick) begin
                        st_d.cnt = '0;
                    end else if (tick) begin
                        if (st_q.cnt >= period - 1'b1) begin
                            st_d.st    = WD_BARK;
                            st_d.cnt   = '0;
                            st_d.pulse = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (st_q.cnt >= lowlen - 1'b1) begin
                            st_d.st  = WD_RUN;
                            st_d.cnt = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st       <= WD_RUN;
            st_q.cnt      <= '0;
            st_q.sel_seen <= WD_SEL_OFF;
            st_q.pulse    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bark       = (st_q.st == WD_BARK);
    assign fail_pulse = st_q.pulse;

    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rst |=> !bark); // R10

    AST_OFF_NEVER_BARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == WD_SEL_OFF) |=> !bark); // R5

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fail_pulse |=> !fail_pulse); // R6

    AST_PULSE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        fail_pulse |-> (bark && !$past(bark))); // R6

    AST_BARK_LEAVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bark) |-> ($past(tick) || $past(hold_rst) || $past(sel) != $past(st_q.sel_seen) || $past(sel) == WD_SEL_OFF)); // R7

endmodule

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog #(
    parameter int unsigned HOLD_T0   = 50,
    parameter int unsigned HOLD_T1   = 200,
    parameter int unsigned HOLD_T2   = 400,
    parameter int unsigned HOLD_T3   = 800,
    parameter int unsigned WDP_T0    = 1400,
    parameter int unsigned WDP_T1    = 200,
    parameter int unsigned WDP_T2    = 25,
    parameter int unsigned WDL_LONG  = 200,
    parameter int unsigned WDL_SHORT = 25,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       vmain_low,
    input  logic       vaux_low,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [1:0] hold_sel,
    input  logic [1:0] wd_sel,
    output logic       rst_hi,
    output logic       rst_lo_n,
    output logic       wd_out_n,
    output logic       aux_fail_n,
    output logic       wd_fail_pulse
);
    logic hold_active;
    logic kick;
    logic bark;

    sup_hold_timer #(
        .HOLD_T0 (HOLD_T0),
        .HOLD_T1 (HOLD_T1),
        .HOLD_T2 (HOLD_T2),
        .HOLD_T3 (HOLD_T3)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_ms),
        .low_flag (vmain_low),
        .sel      (hold_sel),
        .active   (hold_active)
    );

    sup_bus_kick #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .kick    (kick)
    );

    sup_wdog #(
        .WDP_T0    (WDP_T0),
        .WDP_T1    (WDP_T1),
        .WDP_T2    (WDP_T2),
        .WDL_LONG  (WDL_LONG),
        .WDL_SHORT (WDL_SHORT)
    ) u_wd (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_ms),
        .hold_rst   (hold_active),
        .kick       (kick),
        .sel        (wd_sel),
        .bark       (bark),
        .fail_pulse (wd_fail_pulse)
    );

    assign rst_hi     = hold_active;
    assign rst_lo_n   = ~hold_active;
    assign wd_out_n   = ~bark;
    assign aux_fail_n = ~vaux_low;

    AST_RESET_AT_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rst_hi); // R1

endmodule

// File: tb/sup_reset_wdog_tb.sv
module sup_reset_wdog_tb;
    localparam int TDIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       vmain_low = 1'b0;
    logic       vaux_low = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic [1:0] hold_sel = 2'b01;
    logic [1:0] wd_sel = 2'b11;
    logic       rst_hi, rst_lo_n, wd_out_n, aux_fail_n, wd_fail_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sup_reset_wdog u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_ms       (tick_ms),
        .vmain_low     (vmain_low),
        .vaux_low      (vaux_low),
        .scl_in        (scl_in),
        .sda_in        (sda_in),
        .hold_sel      (hold_sel),
        .wd_sel        (wd_sel),
        .rst_hi        (rst_hi),
        .rst_lo_n      (rst_lo_n),
        .wd_out_n      (wd_out_n),
        .aux_fail_n    (aux_fail_n),
        .wd_fail_pulse (wd_fail_pulse)
    );

    function automatic int hold_t(input logic [1:0] c);
        return (c == 2'b00) ? 50 : (c == 2'b01) ? 200 : (c == 2'b10) ? 400 : 800;
    endfunction
    function automatic int per_t(input logic [1:0] c);
        return (c == 2'b00) ? 1400 : (c == 2'b01) ? 200 : 25;
    endfunction
    function automatic int low_t(input logic [1:0] c);
        return (c == 2'b10) ? 25 : 200;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1'b1;
            @(negedge clk);
            tick_ms = 1'b0;
            repeat (TDIV - 1) @(negedge clk);
        end
    endtask

    // counts ticks in which wd_out_n is seen low
    task automatic tick_watch(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            tick_n(1);
            if (!wd_out_n) lows++;
        end
    endtask

    task automatic por();
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic expect_fire(input string req);
        tick_ms = 1'b1;
        @(negedge clk);
        tick_ms = 1'b0;
        chk({req, " wd low on expiry"}, wd_out_n, 0);
        chk({req, " fail pulse"}, wd_fail_pulse, 1);
        @(negedge clk);
        chk({req, " fail pulse one cycle"}, wd_fail_pulse, 0);
        repeat (TDIV - 2) @(negedge clk);
    endtask

    task automatic bus_set(input logic c, input logic d);
        scl_in = c;
        sda_in = d;
        cyc(3);
    endtask
    task automatic bus_start();
        bus_set(0, 1); bus_set(1, 1); bus_set(1, 0); bus_set(0, 0);
    endtask
    task automatic bus_data();
        bus_set(0, 1); bus_set(0, 0); bus_set(0, 1); bus_set(0, 0);
    endtask
    task automatic bus_stop();
        bus_set(0, 0); bus_set(1, 0); bus_set(1, 1);
        cyc(6);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lows;
        cyc(2);
        // R1: state under reset
        chk("R1 rst_hi in reset", rst_hi, 1);
        chk("R1 rst_lo_n in reset", rst_lo_n, 0);
        chk("R1 wd_out_n in reset", wd_out_n, 1);
        chk("R1 wd_fail_pulse in reset", wd_fail_pulse, 0);
        rst_n = 1'b1;

        // R2: hold time sweep over all codes
        for (int h = 0; h < 4; h++) begin
            hold_sel = 2'(h);
            por();
            tick_n(hold_t(hold_sel) - 1);
            chk("R2 reset held before hold end", rst_hi, 1);
            chk("R1 low polarity while held", rst_lo_n, 0);
            tick_n(1);
            chk("R2 reset released at hold end", rst_hi, 0);
            chk("R1 low polarity after release", rst_lo_n, 1);
        end

        // R3: main supply sag restarts the hold
        vmain_low = 1'b1;
        cyc(1);
        chk("R3 reset on sag", rst_hi, 1);
        tick_n(300);
        chk("R3 reset held during sag", rst_hi, 1);
        vmain_low = 1'b0;
        tick_n(hold_t(hold_sel) - 1);
        chk("R3 reset held after sag clears", rst_hi, 1);
        tick_n(1);
        chk("R3 reset released after full hold", rst_hi, 0);

        // R4: second supply flag passes straight through
        vaux_low = 1'b1;
        #1;
        chk("R4 aux fail asserted", aux_fail_n, 0);
        rst_n = 1'b0;
        #1;
        chk("R4 aux fail during reset", aux_fail_n, 0);
        rst_n = 1'b1;
        vaux_low = 1'b0;
        #1;
        chk("R4 aux fail cleared", aux_fail_n, 1);

        // R5: disabled watchdog never fires
        hold_sel = 2'b00;
        wd_sel = 2'b11;
        por();
        tick_watch(1600, lows);
        chk("R5 disabled watchdog low ticks", lows, 0);

        // R6/R7/R10: period and low time sweep
        for (int c = 0; c < 3; c++) begin
            wd_sel = 2'(c);
            por();
            tick_watch(50, lows);
            chk("R10 watchdog quiet during reset hold", lows, 0);
            tick_n(per_t(wd_sel) - 1);
            chk("R6 watchdog high before period", wd_out_n, 1);
            expect_fire("R6");
            tick_n(low_t(wd_sel) - 1);
            chk("R7 watchdog still low", wd_out_n, 0);
            tick_n(1);
            chk("R7 watchdog released after low time", wd_out_n, 1);
            tick_n(per_t(wd_sel) - 1);
            chk("R7 restarted count high", wd_out_n, 1);
            expect_fire("R7 second expiry");
            tick_n(low_t(wd_sel));
        end

        // R8: start then stop restarts the count
        wd_sel = 2'b01;
        por();
        tick_n(50);
        tick_n(150);
        bus_start();
        bus_stop();
        tick_n(199);
        chk("R8 kicked watchdog high", wd_out_n, 1);
        expect_fire("R8");
        tick_n(200);
        tick_n(150);
        bus_start();
        bus_data();
        bus_stop();
        tick_n(199);
        chk("R8 kick with data bits high", wd_out_n, 1);
        expect_fire("R8 with data");
        tick_n(200);

        // R9: stop alone and data changes do not restart
        tick_n(150);
        bus_set(0, 1);
        bus_data();
        bus_stop();
        tick_n(49);
        chk("R9 unkicked still high", wd_out_n, 1);
        expect_fire("R9 no restart");
        tick_n(200);

        // R11: code change clears the count
        wd_sel = 2'b10;
        cyc(2);
        tick_n(20);
        wd_sel = 2'b01;
        cyc(2);
        tick_n(199);
        chk("R11 reloaded count high", wd_out_n, 1);
        expect_fire("R11");
        tick_n(200);

        // R10: sag mid-period clears the watchdog
        wd_sel = 2'b10;
        cyc(2);
        tick_n(20);
        vmain_low = 1'b1;
        cyc(2);
        vmain_low = 1'b0;
        tick_watch(50, lows);
        chk("R10 quiet while reset held", lows, 0);
        tick_n(24);
        chk("R10 count restarted after release", wd_out_n, 1);
        expect_fire("R10");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule